// File: doc/BRIEF.md
# RV32I Instruction Decoder and Control Unit

This block is the purely combinational decode stage of a single-cycle RV32I core. It takes one 32-bit instruction word and splits out the three register addresses. It rebuilds the sign-extended immediate of every encoding format, and it also picks the immediate that belongs to the decoded instruction class. Alongside these it produces the control for the datapath that follows: a register-write enable, a write-back source select, the two ALU operand selects and a 4-bit ALU operation code.

Opcode decoding, immediate bit reassembly and the per-class policy for operands and write-back are folded into one internal control word. That word is built from the opcode, and the ALU code is then refined from funct3 and instruction bit 30. Fence, CSR, environment-call and any unrecognised opcodes decode as no-operations that write no register. Branch resolution, memory access and the register file sit outside this block.

Top module: `rv_instr_decoder`

## Requirements
- R1: `imm_b` is the branch offset rebuilt as {instr[31], instr[7], instr[30:25], instr[11:8], 0} and sign-extended from its bit 12 to 32 bits.
- R2: `imm_s` is the store offset {instr[31:25], instr[11:7]}, sign-extended from its bit 11 to 32 bits.
- R3: `imm_j` is the jump offset {instr[31], instr[19:12], instr[20], instr[30:21], 0}, sign-extended from its bit 20 to 32 bits.
- R4: `imm_i` is instr[31:20] sign-extended to 32 bits, and `imm_u` is instr[31:12] in bits 31:12 with zeros in bits 11:0.
- R5: `wb_sel` is 1 (memory) for loads (opcode 0000011), 2 (PC+4) for JAL (1101111) and JALR (1100111), and 0 (ALU result) for every other opcode.
- R6: `reg_we` is 0 for stores (0100011), branches (1100011), fence (0001111), system/CSR (1110011) and every unrecognised opcode. It is 1 for LOAD, OP-IMM (0010011), OP (0110011), LUI (0110111), AUIPC (0010111), JAL and JALR when the destination is not x0.
- R7: a destination field instr[11:7] of zero forces `reg_we` to 0 for every opcode.
- R8: `op1_sel` is 1 (PC) for branches, JAL and AUIPC, and 2 (constant zero) for LUI, so that the ALU passes the upper immediate through as the write-back value. It is 0 (rs1) for all other opcodes.
- R9: `op2_imm` is 0 (rs2) only for OP; it is 1 (immediate) for every other opcode.
- R10: for OP, `alu_op` follows funct3 = instr[14:12] and instr[30]. The codes are ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9. funct3 000 gives SUB when instr[30] is 1, and funct3 101 gives SRA when instr[30] is 1.
- R11: for OP-IMM, `alu_op` uses the same funct3 map. instr[30] picks SRA over SRL for funct3 101 and is ignored for every other funct3, so addi is always ADD.
- R12: every opcode other than OP and OP-IMM yields `alu_op` = ADD (0).
- R13: `imm` carries `imm_i` for loads, OP-IMM and JALR, `imm_s` for stores, `imm_b` for branches, `imm_u` for LUI and AUIPC, `imm_j` for JAL, and zero for all other opcodes.
- R14: `rs1_addr` = instr[19:15], `rs2_addr` = instr[24:20] and `rd_addr` = instr[11:7] for every instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode |
| rs1_addr | output | 5 | First source register index |
| rs2_addr | output | 5 | Second source register index |
| rd_addr | output | 5 | Destination register index |
| imm_i | output | 32 | Sign-extended I-format immediate |
| imm_s | output | 32 | Sign-extended S-format immediate |
| imm_b | output | 32 | Sign-extended B-format immediate |
| imm_u | output | 32 | U-format immediate, low 12 bits zero |
| imm_j | output | 32 | Sign-extended J-format immediate |
| imm | output | 32 | Immediate selected for the decoded class |
| reg_we | output | 1 | Register write enable, suppressed for x0 |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| op1_sel | output | 2 | ALU operand 1: 0 rs1, 1 PC, 2 zero |
| op2_imm | output | 1 | ALU operand 2: 1 immediate, 0 rs2 |
| alu_op | output | 4 | ALU operation code |

## Verification
The data width is fixed at the 32 bits of the base integer set, so the bench builds the block with its package defaults and has no parameter to sweep. At that width the sign bit of each immediate lands at the top of the word. This brings the most negative offset, the largest positive offset and the isolated bit 11 of the B and J formats within reach of direct checks. The immediate and ALU-code checks are written against field encodings assembled in the bench. Each instruction class, including fence and system words and writes aimed at x0, is compared against the expected selects.

// File: rtl/rv_dec_pkg.sv
package rv_dec_pkg;

  localparam int XLEN  = 32;
  localparam int OPC_W = 7;
  localparam int REG_W = 5;
  localparam int ALU_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC4 = 2'd2} wb_src_e;
  typedef enum logic [1:0] {OP1_RS1 = 2'd0, OP1_PC = 2'd1, OP1_ZERO = 2'd2} op1_src_e;
  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
  } imm_fmt_e;
  typedef enum logic [1:0] {ACLS_ADD, ACLS_REG, ACLS_IMM} alu_cls_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT  = 4'd3,
    ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_OR  = 4'd8, ALU_AND = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic     writes;
    wb_src_e  wb;
    op1_src_e op1;
    logic     op2_imm;
    imm_fmt_e fmt;
    alu_cls_e acls;
  } ctrl_t;

endpackage

// File: rtl/rv_imm_unpack.sv
module rv_imm_unpack
  import rv_dec_pkg::*;
(
  input  logic [31:7]     ins,
  output logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] imm_s,
  output logic [XLEN-1:0] imm_b,
  output logic [XLEN-1:0] imm_u,
  output logic [XLEN-1:0] imm_j
);
  localparam int I_W = 12;
  localparam int B_W = 13;
  localparam int J_W = 21;
  localparam int U_W = 20;

  logic sgn;
  assign sgn = ins[31];

  assign imm_i = {{(XLEN-I_W){sgn}}, ins[31:20]};
  assign imm_s = {{(XLEN-I_W){sgn}}, ins[31:25], ins[11:7]};
  assign imm_b = {{(XLEN-B_W){sgn}}, sgn, ins[7], ins[30:25], ins[11:8], 1'b0};
  assign imm_u = {ins[31:12], {(XLEN-U_W){1'b0}}};
  assign imm_j = {{(XLEN-J_W){sgn}}, sgn, ins[19:12], ins[20], ins[30:21], 1'b0};
endmodule

// File: rtl/rv_class_ctrl.sv
module rv_class_ctrl
  import rv_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl = '{writes: 1'b0, wb: WB_ALU, op1: OP1_RS1, op2_imm: 1'b1,
             fmt: FMT_NONE, acls: ACLS_ADD};
    unique case (opcode)
      OPC_LOAD:   begin ctrl.writes = 1'b1; ctrl.wb = WB_MEM; ctrl.fmt = FMT_I; end
      OPC_OPIMM:  begin ctrl.writes = 1'b1; ctrl.fmt = FMT_I; ctrl.acls = ACLS_IMM; end
      OPC_OP:     begin ctrl.writes = 1'b1; ctrl.op2_imm = 1'b0; ctrl.acls = ACLS_REG; end
      OPC_LUI:    begin ctrl.writes = 1'b1; ctrl.op1 = OP1_ZERO; ctrl.fmt = FMT_U; end
      OPC_AUIPC:  begin ctrl.writes = 1'b1; ctrl.op1 = OP1_PC; ctrl.fmt = FMT_U; end
      OPC_JAL:    begin ctrl.writes = 1'b1; ctrl.wb = WB_PC4; ctrl.op1 = OP1_PC;
                        ctrl.fmt = FMT_J; end
      OPC_JALR:   begin ctrl.writes = 1'b1; ctrl.wb = WB_PC4; ctrl.fmt = FMT_I; end
      OPC_STORE:  begin ctrl.fmt = FMT_S; end
      OPC_BRANCH: begin ctrl.op1 = OP1_PC; ctrl.fmt = FMT_B; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/rv_alu_sel.sv
module rv_alu_sel
  import rv_dec_pkg::*;
(
  input  alu_cls_e acls,
  input  logic [2:0] funct3,
  input  logic     alt,
  output alu_op_e  op
);
  logic sub_ok;
  assign sub_ok = (acls == ACLS_REG) && alt;

  always_comb begin
    op = ALU_ADD;
    if (acls != ACLS_ADD) begin
      unique case (funct3)
        3'b000: op = sub_ok ? ALU_SUB : ALU_ADD;
        3'b001: op = ALU_SLL;
        3'b010: op = ALU_SLT;
        3'b011: op = ALU_SLTU;
        3'b100: op = ALU_XOR;
        3'b101: op = alt ? ALU_SRA : ALU_SRL;
        3'b110: op = ALU_OR;
        3'b111: op = ALU_AND;
        default: op = ALU_ADD;
      endcase
    end
  end
endmodule

// File: rtl/rv_instr_decoder.sv
module rv_instr_decoder
  import rv_dec_pkg::*;
(
  input  logic [31:0]      instr,
  output logic [REG_W-1:0] rs1_addr,
  output logic [REG_W-1:0] rs2_addr,
  output logic [REG_W-1:0] rd_addr,
  output logic [XLEN-1:0]  imm_i,
  output logic [XLEN-1:0]  imm_s,
  output logic [XLEN-1:0]  imm_b,
  output logic [XLEN-1:0]  imm_u,
  output logic [XLEN-1:0]  imm_j,
  output logic [XLEN-1:0]  imm,
  output logic             reg_we,
  output logic [1:0]       wb_sel,
  output logic [1:0]       op1_sel,
  output logic             op2_imm,
  output logic [ALU_W-1:0] alu_op
);
  ctrl_t   ctrl;
  alu_op_e op_enum;

  assign rs1_addr = instr[19:15];
  assign rs2_addr = instr[24:20];
  assign rd_addr  = instr[11:7];

  rv_imm_unpack u_imm (
    .ins   (instr[31:7]),
    .imm_i (imm_i),
    .imm_s (imm_s),
    .imm_b (imm_b),
    .imm_u (imm_u),
    .imm_j (imm_j)
  );

  rv_class_ctrl u_ctrl (
    .opcode (instr[6:0]),
    .ctrl   (ctrl)
  );

  rv_alu_sel u_alu (
    .acls   (ctrl.acls),
    .funct3 (instr[14:12]),
    .alt    (instr[30]),
    .op     (op_enum)
  );

  always_comb begin
    unique case (ctrl.fmt)
      FMT_I:   imm = imm_i;
      FMT_S:   imm = imm_s;
      FMT_B:   imm = imm_b;
      FMT_U:   imm = imm_u;
      FMT_J:   imm = imm_j;
      default: imm = '0;
    endcase
  end

  assign reg_we  = ctrl.writes && (rd_addr != '0);
  assign wb_sel  = ctrl.wb;
  assign op1_sel = ctrl.op1;
  assign op2_imm = ctrl.op2_imm;
  assign alu_op  = op_enum;
endmodule

// File: rtl/rv_instr_decoder_chk.sv
module rv_instr_decoder_chk
  import rv_dec_pkg::*;
(
  input logic [OPC_W-1:0] opc,
  input logic [REG_W-1:0] rd,
  input logic             reg_we,
  input logic [1:0]       wb_sel,
  input logic [1:0]       op1_sel,
  input logic             op2_imm,
  input logic [XLEN-1:0]  imm
);
  always_comb begin
    // R6
    store_branch_nowrite_chk: assert (!((opc == OPC_STORE || opc == OPC_BRANCH) && reg_we))
      else $error("store or branch raised register write");
    // R7
    x0_nowrite_chk: assert (!(rd == '0 && reg_we))
      else $error("write to x0 not suppressed");
    // R9
    rtype_alu_wb_chk: assert (op2_imm || wb_sel == WB_ALU)
      else $error("rs2 operand with non-ALU write-back");
    // R5
    mem_wb_operands_chk: assert (wb_sel != WB_MEM || (op1_sel == OP1_RS1 && op2_imm))
      else $error("load write-back without rs1+imm address");
    // R8
    pc_op1_wb_chk: assert (!(op1_sel == OP1_PC && reg_we) || wb_sel != WB_MEM)
      else $error("PC operand paired with memory write-back");
    // R13
    lui_low_zero_chk: assert (opc != OPC_LUI || imm[11:0] == '0)
      else $error("upper immediate has nonzero low bits");
  end
endmodule

bind rv_instr_decoder rv_instr_decoder_chk u_chk (
  .opc     (instr[6:0]),
  .rd      (rd_addr),
  .reg_we  (reg_we),
  .wb_sel  (wb_sel),
  .op1_sel (op1_sel),
  .op2_imm (op2_imm),
  .imm     (imm)
);

// File: tb/tb_rv_instr_decoder.sv
module tb_rv_instr_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr = '0;
  logic [4:0]  rs1_addr, rs2_addr, rd_addr;
  logic [31:0] imm_i, imm_s, imm_b, imm_u, imm_j, imm;
  logic        reg_we, op2_imm;
  logic [1:0]  wb_sel, op1_sel;
  logic [3:0]  alu_op;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  rv_instr_decoder dut (
    .instr(instr), .rs1_addr(rs1_addr), .rs2_addr(rs2_addr), .rd_addr(rd_addr),
    .imm_i(imm_i), .imm_s(imm_s), .imm_b(imm_b), .imm_u(imm_u), .imm_j(imm_j),
    .imm(imm), .reg_we(reg_we), .wb_sel(wb_sel), .op1_sel(op1_sel),
    .op2_imm(op2_imm), .alu_op(alu_op)
  );

  localparam logic [6:0] LOAD = 7'b0000011, OPIMM = 7'b0010011, AUIPC = 7'b0010111,
    STORE = 7'b0100011, OPR = 7'b0110011, LUI = 7'b0110111, BRANCH = 7'b1100011,
    JALR = 7'b1100111, JAL = 7'b1101111, FENCE = 7'b0001111, SYS = 7'b1110011;

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OPR};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] v, logic [4:0] rs1, logic [2:0] f3,
                                        logic [4:0] rd, logic [6:0] op);
    return {v, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] v, logic [4:0] rs2, logic [4:0] rs1);
    return {v[11:5], rs2, rs1, 3'b010, v[4:0], STORE};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] v, logic [4:0] rs2, logic [4:0] rs1);
    return {v[12], v[10:5], rs2, rs1, 3'b000, v[4:1], v[11], BRANCH};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] v, logic [4:0] rd);
    return {v[20], v[10:1], v[11], v[19:12], rd, JAL};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  task automatic t_idle;
    apply(32'h0000_0000);
    chk("R6 idle word reg_we", {31'b0, reg_we}, 32'd0);
    chk("R13 idle word imm", imm, 32'd0);
    chk("R12 idle word alu_op", {28'b0, alu_op}, 32'd0);
  endtask

  task automatic t_fields;
    apply(enc_r(7'b0, 5'd21, 5'd10, 3'b000, 5'd31));
    chk("R14 rs1", {27'b0, rs1_addr}, 32'd10);
    chk("R14 rs2", {27'b0, rs2_addr}, 32'd21);
    chk("R14 rd", {27'b0, rd_addr}, 32'd31);
  endtask

  task automatic t_rtype_alu;
    logic [3:0] exp_plain [8] = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9};
    for (int f = 0; f < 8; f++) begin
      apply(enc_r(7'b0, 5'd2, 5'd1, 3'(f), 5'd3));
      chk($sformatf("R10 OP funct3=%0d", f), {28'b0, alu_op}, {28'b0, exp_plain[f]});
    end
    apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3));
    chk("R10 sub", {28'b0, alu_op}, 32'd1);
    apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b101, 5'd3));
    chk("R10 sra", {28'b0, alu_op}, 32'd7);
  endtask

  task automatic t_itype_alu;
    apply(enc_i(12'h400, 5'd1, 3'b000, 5'd2, OPIMM));
    chk("R11 addi with bit30 stays add", {28'b0, alu_op}, 32'd0);
    apply(enc_i(12'h403, 5'd1, 3'b101, 5'd2, OPIMM));
    chk("R11 srai", {28'b0, alu_op}, 32'd7);
    apply(enc_i(12'h003, 5'd1, 3'b101, 5'd2, OPIMM));
    chk("R11 srli", {28'b0, alu_op}, 32'd6);
    apply(enc_i(12'h4FF, 5'd1, 3'b100, 5'd2, OPIMM));
    chk("R11 xori with bit30", {28'b0, alu_op}, 32'd5);
    apply(enc_i(12'h401, 5'd1, 3'b001, 5'd2, OPIMM));
    chk("R11 slli", {28'b0, alu_op}, 32'd2);
  endtask

  task automatic t_imm_b;
    logic [12:0] vals [4] = '{13'h1000, 13'h0FFE, 13'h1FFE, 13'h0800};
    foreach (vals[k]) begin
      apply(enc_b(vals[k], 5'd4, 5'd5));
      chk($sformatf("R1 imm_b case %0d", k), imm_b, {{19{vals[k][12]}}, vals[k]});
    end
  endtask

  task automatic t_imm_s;
    logic [11:0] vals [3] = '{12'h800, 12'h7FF, 12'hFFF};
    foreach (vals[k]) begin
      apply(enc_s(vals[k], 5'd6, 5'd7));
      chk($sformatf("R2 imm_s case %0d", k), imm_s, {{20{vals[k][11]}}, vals[k]});
    end
  endtask

  task automatic t_imm_j;
    logic [20:0] vals [4] = '{21'h100000, 21'h0FFFFE, 21'h000800, 21'h1FFFFE};
    foreach (vals[k]) begin
      apply(enc_j(vals[k], 5'd1));
      chk($sformatf("R3 imm_j case %0d", k), imm_j, {{11{vals[k][20]}}, vals[k]});
    end
  endtask

  task automatic t_imm_iu;
    apply(enc_i(12'hFFF, 5'd1, 3'b000, 5'd2, OPIMM));
    chk("R4 imm_i negative", imm_i, 32'hFFFF_FFFF);
    apply(enc_i(12'h7FF, 5'd1, 3'b000, 5'd2, OPIMM));
    chk("R4 imm_i positive", imm_i, 32'h0000_07FF);
    apply({20'hABCDE, 5'd9, LUI});
    chk("R4 imm_u", imm_u, 32'hABCD_E000);
  endtask

  task automatic t_class(string nm, logic [31:0] w, logic we, logic [1:0] wb,
                         logic [1:0] o1, logic o2, logic [31:0] eimm);
    apply(w);
    chk({"R6 reg_we ", nm}, {31'b0, reg_we}, {31'b0, we});
    chk({"R5 wb_sel ", nm}, {30'b0, wb_sel}, {30'b0, wb});
    chk({"R8 op1_sel ", nm}, {30'b0, op1_sel}, {30'b0, o1});
    chk({"R9 op2_imm ", nm}, {31'b0, op2_imm}, {31'b0, o2});
    chk({"R13 imm ", nm}, imm, eimm);
  endtask

  task automatic t_classes;
    t_class("load",   enc_i(12'hFF0, 5'd1, 3'b010, 5'd2, LOAD), 1, 2'd1, 2'd0, 1, 32'hFFFF_FFF0);
    chk("R12 load alu_op", {28'b0, alu_op}, 32'd0);
    t_class("opimm",  enc_i(12'h005, 5'd1, 3'b000, 5'd2, OPIMM), 1, 2'd0, 2'd0, 1, 32'd5);
    t_class("op",     enc_r(7'b0, 5'd3, 5'd1, 3'b000, 5'd2), 1, 2'd0, 2'd0, 0, 32'd0);
    t_class("lui",    {20'h12345, 5'd2, LUI}, 1, 2'd0, 2'd2, 1, 32'h1234_5000);
    t_class("auipc",  {20'h80000, 5'd2, AUIPC}, 1, 2'd0, 2'd1, 1, 32'h8000_0000);
    chk("R12 auipc alu_op", {28'b0, alu_op}, 32'd0);
    t_class("jal",    enc_j(21'h000010, 5'd1), 1, 2'd2, 2'd1, 1, 32'd16);
    t_class("jalr",   enc_i(12'hFFC, 5'd5, 3'b000, 5'd1, JALR), 1, 2'd2, 2'd0, 1, 32'hFFFF_FFFC);
    t_class("store",  enc_s(12'h010, 5'd3, 5'd4), 0, 2'd0, 2'd0, 1, 32'd16);
    t_class("branch", enc_b(13'h1FF8, 5'd3, 5'd4), 0, 2'd0, 2'd1, 1, 32'hFFFF_FFF8);
    chk("R12 branch alu_op", {28'b0, alu_op}, 32'd0);
    t_class("fence",  enc_i(12'h0FF, 5'd0, 3'b000, 5'd5, FENCE), 0, 2'd0, 2'd0, 1, 32'd0);
    t_class("csrrw",  enc_i(12'h300, 5'd1, 3'b001, 5'd5, SYS), 0, 2'd0, 2'd0, 1, 32'd0);
  endtask

  task automatic t_x0;
    apply(enc_i(12'h001, 5'd1, 3'b000, 5'd0, OPIMM));
    chk("R7 addi to x0", {31'b0, reg_we}, 32'd0);
    apply(enc_j(21'h000008, 5'd0));
    chk("R7 jal to x0", {31'b0, reg_we}, 32'd0);
    apply({20'h00001, 5'd0, LUI});
    chk("R7 lui to x0", {31'b0, reg_we}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_fields();
    t_rtype_alu();
    t_itype_alu();
    t_imm_b();
    t_imm_s();
    t_imm_j();
    t_imm_iu();
    t_classes();
    t_x0();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule